// File: doc/BRIEF.md
# SDRAM Command Timing Scheduler

This block sits between a simple request/acknowledge user port and the command pins of a four-bank SDRAM with 12-bit row and 8-bit column addresses. For each user request it opens the addressed row, waits the row-to-column delay and issues a single read or write with auto-precharge. The row is then closed by the device, so the controller keeps no row open between requests. Every minimum spacing between commands is held in a small set of down-counters. A new command leaves only when every counter that guards it has reached zero.

After reset the scheduler runs the power-up sequence on its own:
- a quiet wait,
- a precharge of all banks,
- a parameter-set number of auto-refresh commands,
- a mode register load.

Only after that does it accept user traffic. A refresh tick from an external interval timer raises a pending refresh. That refresh goes out at the first legal cycle, ahead of any waiting user request.

Top module: `sdram_cmd_sched`

## Requirements
- R1: While reset is held, the command pins show NOP, `req_ack_o` is 0 and `init_done_o` is 0.
- R2: After reset, no command other than NOP appears for at least INIT_CYC clocks. The sequence is then exactly: precharge with address bit 10 high, INIT_REFS auto-refreshes, then a mode register load with MODE_WORD on the address and bank 0. `init_done_o` rises in the cycle of that mode load. No activate appears before it.
- R3: The pins {cs_n, ras_n, cas_n, we_n} carry these encodings:
  - NOP 0111
  - activate 0011
  - read 0101
  - write 0100
  - precharge 0010
  - auto-refresh 0001
  - mode load 0000
- R4: A read or write appears exactly T_RCD clocks after its activate.
- R5: Two activates, or an activate and a following refresh, are at least max(T_RC, T_RAS+T_RP) clocks apart. With a request waiting after a read, the next activate comes exactly at that spacing.
- R6: An activate or refresh comes at least T_DAL clocks after a write. After a write, a waiting request is activated at exactly max(T_RC, T_RAS+T_RP, T_RCD+T_DAL) clocks after the previous activate.
- R7: Any command comes at least T_RFC clocks after a refresh, at least T_RP after a precharge and at least T_MRD after a mode load.
- R8: The request address is packed as {bank, row, column} from MSB to LSB. The activate carries the bank on `ba_o` and the row on `addr_o`. The read or write carries the same bank and the column on `addr_o[7:0]`, with bit 10 set (auto-precharge) and all other bits 0.
- R9: `req_ack_o` is high exactly in the cycle the read or write is on the pins, and in no other cycle. Write data belongs to that same cycle.
- R10: A refresh tick that arrives together with a user request while idle is served first. The refresh goes out at once and the activate follows exactly T_RFC clocks later.
- R11: A refresh tick received during power-up is held and goes out exactly T_MRD clocks after the mode load.
- R12: With no request and no pending refresh, the pins stay at NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | User request pending; held until acknowledged |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 22 | {bank, row, column} |
| refresh_tick_i | input | 1 | One-cycle pulse asking for an auto-refresh |
| req_ack_o | output | 1 | Request taken; write data cycle |
| init_done_o | output | 1 | Power-up sequence complete |
| cmd_cs_n_o | output | 1 | Chip select, active low |
| cmd_ras_n_o | output | 1 | Row strobe, active low |
| cmd_cas_n_o | output | 1 | Column strobe, active low |
| cmd_we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | 12 | Row, column or mode word; bit 10 = auto-precharge / all banks |

## Verification
A guard counter loaded with a wrong value, or a state that advances early, shows at the pins as a command spacing one or more clocks off. It shows at the first command that counter guards. The bench therefore timestamps every command it sees and checks both lower bounds and exact spacings when requests follow back to back. A lost refresh flag shows up as a missing refresh command before the next activate. A wrong latch of the request fields shows on the bank and address of the very next read or write.

// File: rtl/sdram_sched_pkg.sv
package sdram_sched_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    ST_BOOT, ST_BOOT_REF, ST_BOOT_MRS, ST_IDLE, ST_COL
  } state_e;
endpackage

// File: rtl/sdram_gap_cnt.sv
module sdram_gap_cnt #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= W'(RST_VAL);
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_pin_drive.sv
module sdram_pin_drive
  import sdram_sched_pkg::*;
(
  input  cmd_e cmd_i,
  output logic cs_n_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);
  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_i;
endmodule

// File: rtl/sdram_cmd_sched.sv
module sdram_cmd_sched
  import sdram_sched_pkg::*;
#(
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned ROW_W     = 12,
  parameter int unsigned COL_W     = 8,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RAS     = 7,
  parameter int unsigned T_RC      = 10,
  parameter int unsigned T_RFC     = 10,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned T_DAL     = 5,
  parameter int unsigned INIT_CYC  = 16,
  parameter int unsigned INIT_REFS = 2,
  parameter int unsigned MODE_WORD = 'h030
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_valid_i,
  input  logic                            req_write_i,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr_i,
  input  logic                            refresh_tick_i,
  output logic                            req_ack_o,
  output logic                            init_done_o,
  output logic                            cmd_cs_n_o,
  output logic                            cmd_ras_n_o,
  output logic                            cmd_cas_n_o,
  output logic                            cmd_we_n_o,
  output logic [BANK_W-1:0]               ba_o,
  output logic [ROW_W-1:0]                addr_o
);
  localparam int unsigned ADDR_W = BANK_W + ROW_W + COL_W;
  localparam int unsigned AP_BIT = 10;
  localparam int unsigned T_A2A  = (T_RC > T_RAS + T_RP) ? T_RC : T_RAS + T_RP;
  localparam int unsigned CNT_W  = $clog2(INIT_CYC + T_A2A + T_RFC + T_DAL + 2);
  localparam int unsigned REFS_W = $clog2(INIT_REFS + 1);

  state_e              state_q, state_d;
  cmd_e                cmd_q, cmd_d;
  logic [BANK_W-1:0]   ba_q, ba_d, bank_q;
  logic [ROW_W-1:0]    addr_q, addr_d;
  logic [COL_W-1:0]    col_q;
  logic                wr_q, ack_q, ack_d, done_q, done_set;
  logic                ref_pend_q, ref_clr, ref_req;
  logic [REFS_W-1:0]   refs_q;
  logic                refs_dec, latch_req;

  logic                gap_ld, rc_ld, dal_ld;
  logic [CNT_W-1:0]    gap_val;
  logic                gap_z, rc_z, dal_z;

  sdram_gap_cnt #(.W(CNT_W), .RST_VAL(INIT_CYC - 1)) u_gap (
    .clk_i, .rst_ni, .load_i(gap_ld), .load_val_i(gap_val), .zero_o(gap_z));
  sdram_gap_cnt #(.W(CNT_W), .RST_VAL(0)) u_rc (
    .clk_i, .rst_ni, .load_i(rc_ld), .load_val_i(CNT_W'(T_A2A - 1)), .zero_o(rc_z));
  sdram_gap_cnt #(.W(CNT_W), .RST_VAL(0)) u_dal (
    .clk_i, .rst_ni, .load_i(dal_ld), .load_val_i(CNT_W'(T_DAL - 1)), .zero_o(dal_z));

  // tick is honoured in its own cycle so it beats a request arriving with it
  assign ref_req = ref_pend_q | refresh_tick_i;

  always_comb begin
    state_d   = state_q;
    cmd_d     = CMD_NOP;
    ba_d      = '0;
    addr_d    = '0;
    ack_d     = 1'b0;
    gap_ld    = 1'b0;
    gap_val   = '0;
    rc_ld     = 1'b0;
    dal_ld    = 1'b0;
    ref_clr   = 1'b0;
    refs_dec  = 1'b0;
    done_set  = 1'b0;
    latch_req = 1'b0;
    unique case (state_q)
      ST_BOOT: if (gap_z) begin
        cmd_d          = CMD_PRE;
        addr_d[AP_BIT] = 1'b1;
        gap_ld         = 1'b1;
        gap_val        = CNT_W'(T_RP - 1);
        state_d        = ST_BOOT_REF;
      end
      ST_BOOT_REF: if (gap_z) begin
        cmd_d    = CMD_REF;
        gap_ld   = 1'b1;
        gap_val  = CNT_W'(T_RFC - 1);
        refs_dec = 1'b1;
        if (refs_q == REFS_W'(1)) state_d = ST_BOOT_MRS;
      end
      ST_BOOT_MRS: if (gap_z) begin
        cmd_d    = CMD_MRS;
        addr_d   = ROW_W'(MODE_WORD);
        gap_ld   = 1'b1;
        gap_val  = CNT_W'(T_MRD - 1);
        done_set = 1'b1;
        state_d  = ST_IDLE;
      end
      ST_IDLE: if (gap_z && rc_z && dal_z) begin
        if (ref_req) begin
          cmd_d   = CMD_REF;
          gap_ld  = 1'b1;
          gap_val = CNT_W'(T_RFC - 1);
          ref_clr = 1'b1;
        end else if (req_valid_i && !ack_q) begin
          cmd_d     = CMD_ACT;
          ba_d      = req_addr_i[ADDR_W-1 -: BANK_W];
          addr_d    = req_addr_i[COL_W +: ROW_W];
          gap_ld    = 1'b1;
          gap_val   = CNT_W'(T_RCD - 1);
          rc_ld     = 1'b1;
          latch_req = 1'b1;
          state_d   = ST_COL;
        end
      end
      ST_COL: if (gap_z) begin
        cmd_d              = wr_q ? CMD_WR : CMD_RD;
        ba_d               = bank_q;
        addr_d[COL_W-1:0]  = col_q;
        addr_d[AP_BIT]     = 1'b1;
        ack_d              = 1'b1;
        dal_ld             = wr_q;
        state_d            = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_BOOT;
      cmd_q      <= CMD_NOP;
      ba_q       <= '0;
      addr_q     <= '0;
      ack_q      <= 1'b0;
      done_q     <= 1'b0;
      ref_pend_q <= 1'b0;
      refs_q     <= REFS_W'(INIT_REFS);
      bank_q     <= '0;
      col_q      <= '0;
      wr_q       <= 1'b0;
    end else begin
      state_q    <= state_d;
      cmd_q      <= cmd_d;
      ba_q       <= ba_d;
      addr_q     <= addr_d;
      ack_q      <= ack_d;
      done_q     <= done_q | done_set;
      ref_pend_q <= ref_req & ~ref_clr;
      if (refs_dec) refs_q <= refs_q - 1'b1;
      if (latch_req) begin
        bank_q <= req_addr_i[ADDR_W-1 -: BANK_W];
        col_q  <= req_addr_i[COL_W-1:0];
        wr_q   <= req_write_i;
      end
    end
  end

  sdram_pin_drive u_pins (
    .cmd_i(cmd_q), .cs_n_o(cmd_cs_n_o), .ras_n_o(cmd_ras_n_o),
    .cas_n_o(cmd_cas_n_o), .we_n_o(cmd_we_n_o));

  assign ba_o        = ba_q;
  assign addr_o      = addr_q;
  assign req_ack_o   = ack_q;
  assign init_done_o = done_q;
endmodule

// File: rtl/sdram_cmd_sched_chk.sv
module sdram_cmd_sched_chk #(
  parameter int unsigned T_RCD = 3,
  parameter int unsigned T_RP  = 3,
  parameter int unsigned T_RAS = 7,
  parameter int unsigned T_RC  = 10,
  parameter int unsigned T_RFC = 10,
  parameter int unsigned T_MRD = 2,
  parameter int unsigned T_DAL = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ack_o,
  input logic init_done_o,
  input logic cmd_cs_n_o,
  input logic cmd_ras_n_o,
  input logic cmd_cas_n_o,
  input logic cmd_we_n_o,
  input logic a10_i
);
  localparam int unsigned T_A2A = (T_RC > T_RAS + T_RP) ? T_RC : T_RAS + T_RP;
  localparam int unsigned SW    = $clog2(T_A2A + T_RFC + T_DAL + T_MRD + T_RCD + 4) + 1;

  logic [3:0] c;
  assign c = {cmd_cs_n_o, cmd_ras_n_o, cmd_cas_n_o, cmd_we_n_o};

  logic is_act, is_col, is_wr, is_ref, is_pre, is_mrs, is_cmd;
  assign is_act = (c == 4'b0011);
  assign is_wr  = (c == 4'b0100);
  assign is_col = (c == 4'b0101) || is_wr;
  assign is_ref = (c == 4'b0001);
  assign is_pre = (c == 4'b0010);
  assign is_mrs = (c == 4'b0000);
  assign is_cmd = (c != 4'b0111);

  logic [SW-1:0] s_act, s_wr, s_ref, s_pre, s_mrs;

  function automatic logic [SW-1:0] step(input logic ev, input logic [SW-1:0] v);
    if (ev)            return SW'(1);
    else if (&v)       return v;
    else               return v + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_act <= '1; s_wr <= '1; s_ref <= '1; s_pre <= '1; s_mrs <= '1;
    end else begin
      s_act <= step(is_act, s_act);
      s_wr  <= step(is_wr,  s_wr);
      s_ref <= step(is_ref, s_ref);
      s_pre <= step(is_pre, s_pre);
      s_mrs <= step(is_mrs, s_mrs);
    end
  end

  // R4
  rcd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> s_act >= SW'(T_RCD));
  // R5
  rc_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_act || is_ref) |-> s_act >= SW'(T_A2A));
  // R6
  dal_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_act || is_ref) |-> s_wr >= SW'(T_DAL));
  // R7
  rfc_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cmd |-> s_ref >= SW'(T_RFC));
  // R7
  rp_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cmd |-> s_pre >= SW'(T_RP));
  // R7
  mrd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cmd |-> s_mrs >= SW'(T_MRD));
  // R9
  ack_is_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ack_o == is_col);
  // R8
  col_autopre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> a10_i);
  // R2
  act_after_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_act |-> init_done_o);
  // R2
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(init_done_o) |-> 1'b0);
endmodule

bind sdram_cmd_sched sdram_cmd_sched_chk #(
  .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC),
  .T_RFC(T_RFC), .T_MRD(T_MRD), .T_DAL(T_DAL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ack_o(req_ack_o),
  .init_done_o(init_done_o), .cmd_cs_n_o(cmd_cs_n_o),
  .cmd_ras_n_o(cmd_ras_n_o), .cmd_cas_n_o(cmd_cas_n_o),
  .cmd_we_n_o(cmd_we_n_o), .a10_i(addr_o[10])
);

// File: tb/sdram_cmd_sched_test.sv
module sdram_cmd_sched_test;
  localparam int TRCD = 3, TRP = 3, TRAS = 7, TRC = 10, TRFC = 10, TMRD = 2;
  localparam int TDAL = 9, INITC = 8, NREFS = 2, MODEW = 'h030;
  localparam int TA2A = (TRC > TRAS + TRP) ? TRC : TRAS + TRP;
  localparam int TWA  = (TA2A > TRCD + TDAL) ? TA2A : TRCD + TDAL;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, tick = 1'b0;
  logic [21:0] req_addr = '0;
  logic ack, done, cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [11:0] addr;

  always #2 clk = ~clk;

  sdram_cmd_sched #(
    .T_RCD(TRCD), .T_RP(TRP), .T_RAS(TRAS), .T_RC(TRC), .T_RFC(TRFC),
    .T_MRD(TMRD), .T_DAL(TDAL), .INIT_CYC(INITC), .INIT_REFS(NREFS),
    .MODE_WORD(MODEW)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .refresh_tick_i(tick), .req_ack_o(ack),
    .init_done_o(done), .cmd_cs_n_o(cs_n), .cmd_ras_n_o(ras_n),
    .cmd_cas_n_o(cas_n), .cmd_we_n_o(we_n), .ba_o(ba), .addr_o(addr)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // command log and spacing monitor
  int ev_n = 0;
  logic [3:0] ev_cmd [0:255];
  int ev_cyc [0:255];
  logic [11:0] ev_addr [0:255];
  logic [1:0] ev_ba [0:255];
  int t_act = -10000, t_act_prev = -10000, t_wr = -10000, t_ref = -10000;
  int t_pre = -10000, t_mrs = -10000;
  logic [1:0] act_ba, col_ba;
  logic [11:0] act_row, col_addr;
  logic [3:0] col_cmd;

  always @(negedge clk) if (rst_n) begin
    logic [3:0] c;
    c = {cs_n, ras_n, cas_n, we_n};
    if (c != NOP) begin
      if (ev_n < 256) begin
        ev_cmd[ev_n] = c; ev_cyc[ev_n] = cyc; ev_addr[ev_n] = addr; ev_ba[ev_n] = ba;
      end
      ev_n++;
      chk(cyc - t_mrs >= TMRD, "R7 mrs gap", cyc - t_mrs, TMRD);
      chk(cyc - t_pre >= TRP, "R7 pre gap", cyc - t_pre, TRP);
      chk(cyc - t_ref >= TRFC, "R7 ref gap", cyc - t_ref, TRFC);
    end
    if (c == ACT || c == REF) begin
      chk(cyc - t_act >= TA2A, "R5 act gap", cyc - t_act, TA2A);
      chk(cyc - t_wr >= TDAL, "R6 write gap", cyc - t_wr, TDAL);
    end
    if (ack || c == RD || c == WR)
      chk(ack && (c == RD || c == WR), "R9 ack vs column", {28'd0, c}, ack ? 32'd4 : 32'd7);
    case (c)
      ACT: begin
        chk(done, "R2 activate before init", done, 1);
        t_act_prev = t_act; t_act = cyc; act_ba = ba; act_row = addr;
      end
      RD, WR: begin
        chk(cyc - t_act == TRCD, "R4 rcd", cyc - t_act, TRCD);
        chk(addr[10], "R8 auto-precharge bit", addr[10], 1);
        col_cmd = c; col_ba = ba; col_addr = addr;
        if (c == WR) t_wr = cyc;
      end
      REF: t_ref = cyc;
      PRE: t_pre = cyc;
      MRS: begin
        chk(done, "R2 done with mode load", done, 1);
        t_mrs = cyc;
      end
      default: ;
    endcase
  end

  bit prev_w = 1'b0;

  task automatic do_req(input int bank, input int row, input int col, input bit w,
                        input bit b2b, input bit with_tick);
    int start;
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = w;
    req_addr = {bank[1:0], row[11:0], col[7:0]};
    tick = with_tick;
    start = cyc;
    @(posedge clk); #1; tick = 1'b0;
    do begin @(negedge clk); #1; end while (!ack);
    chk(act_ba == 2'(bank), "R8 activate bank", act_ba, bank);
    chk(act_row == 12'(row), "R8 activate row", act_row, row);
    chk(col_ba == 2'(bank), "R8 column bank", col_ba, bank);
    chk(col_addr == (12'h400 | 12'(col)), "R8 column address", col_addr, 'h400 | col);
    chk(col_cmd == (w ? WR : RD), "R3 column encoding", col_cmd, w ? WR : RD);
    if (b2b) chk(t_act - t_act_prev == (prev_w ? TWA : TA2A), prev_w ? "R6 back-to-back after write" :
                 "R5 back-to-back after read", t_act - t_act_prev, prev_w ? TWA : TA2A);
    if (with_tick) begin
      chk(t_ref >= start, "R10 refresh first", t_ref, start);
      chk(t_act - t_ref == TRFC, "R10 activate after refresh", t_act - t_ref, TRFC);
    end
    prev_w = w;
  endtask

  task automatic go_idle(input int n);
    @(posedge clk); #1; req_valid = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == NOP, "R1 reset pins", {cs_n, ras_n, cas_n, we_n}, NOP);
    chk(!ack, "R1 reset ack", ack, 0);
    chk(!done, "R1 reset done", done, 0);
    rst_n = 1'b1;
    // R11 tick during power-up
    @(posedge clk); @(posedge clk); #1 tick = 1'b1;
    @(posedge clk); #1 tick = 1'b0;
    while (!done) @(negedge clk);
    repeat (TMRD + 2) @(negedge clk);
    // R2 power-up order
    chk(ev_cmd[0] == PRE, "R2 first is precharge", ev_cmd[0], PRE);
    chk(ev_cyc[0] >= INITC, "R2 quiet wait", ev_cyc[0], INITC);
    chk(ev_addr[0][10], "R2 precharge all", ev_addr[0][10], 1);
    for (int i = 1; i <= NREFS; i++)
      chk(ev_cmd[i] == REF, "R2 boot refresh", ev_cmd[i], REF);
    chk(ev_cmd[NREFS+1] == MRS, "R2 mode load", ev_cmd[NREFS+1], MRS);
    chk(ev_addr[NREFS+1] == 12'(MODEW), "R2 mode word", ev_addr[NREFS+1], MODEW);
    chk(ev_ba[NREFS+1] == 2'd0, "R2 mode bank", ev_ba[NREFS+1], 0);
    // R11 held tick
    chk(ev_cmd[NREFS+2] == REF, "R11 held refresh", ev_cmd[NREFS+2], REF);
    chk(ev_cyc[NREFS+2] - ev_cyc[NREFS+1] == TMRD, "R11 refresh timing",
        ev_cyc[NREFS+2] - ev_cyc[NREFS+1], TMRD);
    // R12 idle stays NOP
    begin
      int n0;
      repeat (TRFC + 2) @(posedge clk);
      n0 = ev_n;
      repeat (30) @(posedge clk);
      @(negedge clk);
      chk(ev_n == n0, "R12 idle NOP", ev_n - n0, 0);
    end
    // sweep banks and directions back to back
    for (int b = 0; b < 4; b++)
      for (int w = 0; w < 2; w++)
        do_req(b, (b * 'h3A5 + w * 'h111 + 'h800) & 'hFFF, (b * 37 + w * 91 + 5) & 'hFF,
               w[0], !(b == 0 && w == 0), 1'b0);
    // read after write and write after write, edge values
    do_req(3, 'hFFF, 'hFF, 1'b1, 1'b1, 1'b0);
    do_req(0, 'h000, 'h00, 1'b1, 1'b1, 1'b0);
    do_req(2, 'hABC, 'h7E, 1'b0, 1'b1, 1'b0);
    go_idle(30);
    // R10 refresh tick with request
    do_req(1, 'h123, 'h45, 1'b0, 1'b0, 1'b1);
    go_idle(30);
    do_req(2, 'h5A5, 'hA5, 1'b1, 1'b0, 1'b1);
    go_idle(30);
    begin
      int n0;
      n0 = ev_n;
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk(ev_n == n0, "R12 idle after traffic", ev_n - n0, 0);
    end
    finish_run();
  end
endmodule